// File: doc/BRIEF.md
# Cascaded Synchronous Digit Counter

This block is a multi-digit counter made of identical digit stages, three modulo-4 digits by default. Every flip-flop in every stage is clocked by the one system clock. Each stage has a combinational rollover output, and that output is the increment enable of the stage above it. It is never used as a clock. As a result, every digit that changes does so on the same clock edge. No derived clock is created, and no digit lags behind another.

The external increment enable drives the lowest digit. A synchronous clear that all stages share returns the whole count to zero on the next edge and takes priority over incrementing. The rollover of the most significant stage is exported as a carry-out, so a further counter can be cascaded on the same clock. The per-stage modulus is a parameter. It can be changed, for example to build time-of-day digits, but the default is 4.

Top module: `cascade_counter`

## Requirements
- R1: While its increment input is high and clear is low, a digit steps 0, 1, 2, 3 and then back to 0 on successive clock edges.
- R2: With the external increment low and clear low, all digits keep their values across the edge and `carry_o` is 0.
- R3: When `clr` is 1, every digit is 0 after the next clock edge, whatever the increment and the current count are, and `carry_o` is 0 during that cycle.
- R4: `carry_o` is combinational. It is 1 exactly when all digits are 3, `inc_en` is 1 and `clr` is 0. `digits_o` packs digit 0 in bits [1:0], digit 1 in bits [3:2] and digit 2 in bits [5:4].
- R5: A higher digit changes only on the edge on which every digit below it wraps from 3 to 0. With increment held high, `digits_o` therefore follows a base-4 count with no skipped or repeated value.
- R6: When the count goes from 333 to 000, `carry_o` is 1 for that single cycle.
- R7: A clear applied in the cycle where the count is 333 and increment is high gives 000 after the edge, with `carry_o` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for every stage |
| clr | input | 1 | Synchronous clear for all digits; takes priority over increment |
| inc_en | input | 1 | Increment enable for the lowest digit |
| digits_o | output | 6 | Packed digit values, digit 0 in the lowest bits |
| carry_o | output | 1 | Mealy rollover of the most significant digit |

## Verification
The digits are registered, so the effect of an increment or a clear presented in one cycle shows up on `digits_o` after the following rising edge. The bench drives inputs on the falling edge and compares `digits_o` with a base-4 reference on the next falling edge. `carry_o` is combinational and is due in the same cycle as the inputs that cause it. The bench samples it shortly after driving those inputs and before the edge that consumes them. The reference model is an integer counted modulo 64, and its digits are extracted with division. The stimulus includes gaps in the increment enable, a clear issued in the middle of a count, and a clear issued exactly on the full-carry cycle.

// File: rtl/cascade_counter_pkg.sv
`timescale 1ns/1ps
package cascade_counter_pkg;

  // True when a digit value sits at the last value of its modulus.
  function automatic logic f_is_terminal(input int unsigned v, input int unsigned m);
    return (v == m - 1);
  endfunction

  // Successor of a digit value under its modulus.
  function automatic int unsigned f_successor(input int unsigned v, input int unsigned m);
    return (v >= m - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/digit_state_reg.sv
`timescale 1ns/1ps
module digit_state_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    q_o <= d_i;
  end
endmodule

// File: rtl/digit_stage.sv
`timescale 1ns/1ps
module digit_stage
  import cascade_counter_pkg::*;
#(
  parameter int MODULUS = 4,
  localparam int DW = (MODULUS > 2) ? $clog2(MODULUS) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          inc_i,
  output logic [DW-1:0] q_o,
  output logic          roll_o
);
  logic          at_term;
  logic [DW-1:0] succ;
  logic [DW-1:0] d_next;

  assign at_term = f_is_terminal(int'(q_o), MODULUS);
  assign succ    = DW'(f_successor(int'(q_o), MODULUS));
  assign roll_o  = inc_i & at_term & ~clr;

  always_comb begin
    if (clr)        d_next = '0;
    else if (inc_i) d_next = succ;
    else            d_next = q_o;
  end

  digit_state_reg #(.W(DW)) state_i (
    .clk (clk),
    .d_i (d_next),
    .q_o (q_o)
  );

  // R1: a non-terminal digit advances by one when incremented
  a_r1_step: assert property (@(posedge clk) disable iff (clr)
    (inc_i && !at_term) |=> (int'(q_o) == int'($past(q_o)) + 1));

  // R1: a rollover returns the digit to zero
  a_r1_wrap: assert property (@(posedge clk) disable iff (clr)
    roll_o |=> (q_o == '0));

  // R2: no increment, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (clr)
    !inc_i |=> $stable(q_o));

  // R3: clear wins over everything
  a_r3_clear: assert property (@(posedge clk)
    clr |=> (q_o == '0));

  // R1: the value stays inside the modulus
  a_r1_range: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (int'(q_o) < MODULUS));
endmodule

// File: rtl/cascade_counter.sv
`timescale 1ns/1ps
module cascade_counter #(
  parameter int NUM_DIGITS = 3,
  parameter int MODULUS    = 4,
  localparam int DW        = (MODULUS > 2) ? $clog2(MODULUS) : 1,
  localparam int TW        = NUM_DIGITS * DW
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          inc_en,
  output logic [TW-1:0] digits_o,
  output logic          carry_o
);
  // carry_in[k] enables digit k; carry_in[k+1] is digit k's rollover
  logic [NUM_DIGITS:0] carry_in;

  assign carry_in[0] = inc_en;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    logic [DW-1:0] dq;

    digit_stage #(.MODULUS(MODULUS)) stage_i (
      .clk    (clk),
      .clr    (clr),
      .inc_i  (carry_in[k]),
      .q_o    (dq),
      .roll_o (carry_in[k+1])
    );

    assign digits_o[k*DW +: DW] = dq;

    if (k > 0) begin : g_upper
      // R5: an upper digit moves only when the stage below rolls over
      a_r5_upper_hold: assert property (@(posedge clk) disable iff (clr)
        !carry_in[k] |=> $stable(digits_o[k*DW +: DW]));
    end
  end

  assign carry_o = carry_in[NUM_DIGITS];

  // R6: the carry-out is followed by an all-zero count
  a_r6_full_wrap: assert property (@(posedge clk) disable iff (clr)
    carry_o |=> (digits_o == '0));

  // R6: the carry-out lasts a single cycle while counting
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (clr)
    carry_o |=> !carry_o);

  // R3: the carry-out is silent during clear
  a_r3_no_carry: assert property (@(posedge clk)
    clr |-> !carry_o);

  // R4: the carry-out needs the external increment
  a_r4_needs_inc: assert property (@(posedge clk)
    carry_o |-> inc_en);
endmodule

// File: tb/cascade_counter_tb_top.sv
`timescale 1ns/1ps
module cascade_counter_tb_top;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       inc_en = 1'b0;
  logic [5:0] digits_o;
  logic       carry_o;

  int n_checks = 0;
  int n_fail   = 0;
  int ref_cnt  = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  cascade_counter dut_i (
    .clk      (clk),
    .clr      (clr),
    .inc_en   (inc_en),
    .digits_o (digits_o),
    .carry_o  (carry_o)
  );

  // base-4 digits of the reference, packed 2 bits per digit
  function automatic logic [5:0] pack_ref(input int v);
    int d0, d1, d2;
    d0 = v % 4;
    d1 = (v / 4) % 4;
    d2 = (v / 16) % 4;
    return {2'(d2), 2'(d1), 2'(d0)};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at falling edge, check carry, then check digits after edge
  task automatic cyc(input logic i_inc, input logic i_clr, input string req);
    logic exp_carry;
    inc_en = i_inc;
    clr    = i_clr;
    #0.5;
    exp_carry = (!i_clr && i_inc && ref_cnt == 63);
    check({req, " carry"}, {5'b0, carry_o}, {5'b0, exp_carry});
    if (i_clr)      ref_cnt = 0;
    else if (i_inc) ref_cnt = (ref_cnt + 1) % 64;
    @(posedge clk);
    @(negedge clk);
    check({req, " digits"}, digits_o, pack_ref(ref_cnt));
  endtask

  task automatic t_reset();
    @(negedge clk);
    cyc(1'b1, 1'b1, "R3 reset");
  endtask

  task automatic t_run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, "R5 run");
  endtask

  task automatic t_step_digit();
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R1 step");
    check("R1 back to zero", {4'b0, digits_o[1:0]}, 6'd0);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, "R2 hold");
  endtask

  task automatic t_gapped(input int n);
    for (int i = 0; i < n; i++) cyc((i % 3) != 2, 1'b0, "R5 gapped");
  endtask

  task automatic t_full_wrap();
    cyc(1'b1, 1'b1, "R3 clear");
    for (int i = 0; i < 63; i++) cyc(1'b1, 1'b0, "R5 climb");
    check("R4 at 333", digits_o, 6'h3F);
    cyc(1'b0, 1'b0, "R4 no inc at 333");
    cyc(1'b1, 1'b0, "R6 wrap");
    check("R6 zero after wrap", digits_o, 6'h00);
    cyc(1'b1, 1'b0, "R6 after wrap");
  endtask

  task automatic t_clear_mid_carry();
    cyc(1'b1, 1'b1, "R3 clear");
    for (int i = 0; i < 63; i++) cyc(1'b1, 1'b0, "R5 climb");
    cyc(1'b1, 1'b1, "R7 clear on carry");
    check("R7 zero", digits_o, 6'h00);
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, "R5 resume");
    cyc(1'b1, 1'b1, "R3 mid clear");
  endtask

  initial begin
    t_reset();
    t_step_digit();
    t_hold();
    t_run(70);
    t_gapped(80);
    t_full_wrap();
    t_clear_mid_carry();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule